// File: doc/BRIEF.md
# Isochronous IN Interval Flush Controller

This block looks after the transmit buffer of a single isochronous IN endpoint in a USB device controller. It keeps a frame clock running from good SOF packets. When an SOF is corrupted or missing, it supplies the frame tick itself from an internal timer. It divides that frame stream into intervals of 2^sel frames and expects an IN token only in the last frame of each interval. The decoded token stream, the buffer-not-empty flag and the configuration inputs drive two outputs. One is a one-cycle strobe that tells the FIFO to discard stale data at a frame boundary. The other is a one-cycle transmit enable that answers an accepted IN token.

With flushing disabled, every clean IN token is answered and nothing is ever discarded. With flushing enabled, the buffer is emptied on a frame boundary in two cases. The first is when an expected token failed to arrive while data was waiting. The second is when a token arrived damaged, for example with a token CRC failure. The interval counter returns to its cleared state on power-on reset, on an auto-clear write strobe and on a detected bus reset. Counting restarts on the next frame tick after that. Token events are expected away from the cycle that carries a frame tick.

Top module: `iso_in_flush_ctrl`

## Requirements
- R1: While flush_en is 0, every in_tok pulse with in_tok_err low produces a tx_en pulse in the following cycle, whatever interval_sel and the frame phase are, and buf_clear never pulses.
- R2: The interval is 2^interval_sel frames. The first frame tick after the cleared state opens the frame with phase 0. Each later tick advances the phase and wraps it after 2^interval_sel - 1, and only the frame with that last phase expects a token.
- R3: With flush_en 1 and buf_has_data 1 at the boundary tick, if the expected frame that just ended held no clean IN token, buf_clear pulses in the cycle after that tick.
- R4: An IN token with in_tok_err 1 never produces tx_en. With flush_en 1 it causes a buf_clear pulse one cycle after the next frame tick, if buf_has_data is 1 then, in any frame of the interval.
- R5: buf_clear does not pulse at a boundary where buf_has_data is 0.
- R6: A frame tick occurs on each sof_ok pulse. When no sof_ok arrives for FRAME_CYCLES cycles after the previous tick, a fill-in tick is produced in that cycle and acts as a frame boundary in every respect.
- R7: rst_n low, an auto_clr pulse or a bus_reset pulse returns the interval counter to its cleared state and drops token history. No buf_clear results in that cycle, and phase 0 restarts on the next tick.
- R8: buf_clear is high for exactly one cycle, only in the cycle after a frame tick, and at most once per boundary even when a missed token and a damaged token coincide.
- R9: While flush_en is 1, tx_en follows only clean tokens seen inside an expected frame. Tokens in other frames, or while the counter is cleared, are not answered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| sof_ok | input | 1 | Pulse: SOF packet received without error |
| in_tok | input | 1 | Pulse: IN token addressed to this endpoint |
| in_tok_err | input | 1 | Qualifies in_tok: token had a bus or CRC error |
| buf_has_data | input | 1 | Transmit buffer holds data |
| flush_en | input | 1 | Enables interval tracking and flushing |
| interval_sel | input | 3 | Interval exponent, interval = 2^interval_sel frames |
| auto_clr | input | 1 | Pulse: software write of 1 to the auto-clear control |
| bus_reset | input | 1 | Pulse: USB bus reset detected |
| buf_clear | output | 1 | One-cycle strobe that empties the transmit buffer |
| tx_en | output | 1 | One-cycle strobe: send the data packet for the token |

## Verification
A frame phase that is off by one shows up at the next expected frame. A token placed in the frame that the bench models as expected is then either left unanswered on tx_en, or it fails to suppress a buf_clear. Either way the fault is visible within one interval. A fill-in timer with the wrong period moves the boundary, and with it the buf_clear pulse, by a cycle or more at the first dropped SOF. Stale token history that survives a clear source shows up as a spurious or missing buf_clear at the first boundary after that clear. The bench compares both outputs against its own frame model on every cycle, so each of these faults is caught in the cycle where the port diverges.

// File: rtl/iso_flush_pkg.sv
package iso_flush_pkg;
  localparam int unsigned SEL_W   = 3;
  localparam int unsigned PHASE_W = (1 << SEL_W) - 1;

  typedef logic [SEL_W-1:0]   isel_t;
  typedef logic [PHASE_W-1:0] phase_t;

  typedef struct packed {
    logic good;
    logic bad;
  } tok_t;

  // Last phase index of an interval of 2^sel frames.
  function automatic phase_t interval_last(isel_t sel);
    return phase_t'({PHASE_W{1'b1}} >> (PHASE_W - int'(sel)));
  endfunction
endpackage

// File: rtl/sof_fill_timer.sv
module sof_fill_timer #(
  parameter int unsigned FRAME_CYCLES = 48000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sof_ok,
  output logic frame_tick
);
  localparam int unsigned CNT_W = $clog2(FRAME_CYCLES);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             expire;

  always_comb begin
    expire     = (cnt_q == LAST) && !sof_ok;
    frame_tick = sof_ok || expire;
    cnt_d      = frame_tick ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  AST_TIMER_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    sof_ok |=> (cnt_q == '0)); // R6
endmodule

// File: rtl/interval_counter.sv
module interval_counter
  import iso_flush_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  frame_tick,
  input  logic  cnt_clr,
  input  isel_t sel,
  output logic  started,
  output logic  terminal
);
  phase_t phase_q, phase_d, last;
  logic   started_q, started_d;
  logic   reg_en;

  always_comb begin
    last      = interval_last(sel);
    reg_en    = cnt_clr || frame_tick;
    started_d = started_q;
    phase_d   = phase_q;
    if (cnt_clr) begin
      started_d = 1'b0;
      phase_d   = '0;
    end else if (frame_tick) begin
      if (!started_q) begin
        started_d = 1'b1;
        phase_d   = '0;
      end else begin
        phase_d = (phase_q >= last) ? '0 : phase_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      started_q <= 1'b0;
      phase_q   <= '0;
    end else if (reg_en) begin
      started_q <= started_d;
      phase_q   <= phase_d;
    end
  end

  assign started  = started_q;
  assign terminal = started_q && (phase_q >= last);

  AST_CLEAR_IDLES: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_clr |=> !started); // R7
  AST_FIRST_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(started_q) |-> (phase_q == '0)); // R2
  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame_tick && !cnt_clr) |=> $stable(phase_q)); // R2
endmodule

// File: rtl/flush_decider.sv
module flush_decider
  import iso_flush_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic frame_tick,
  input  logic cnt_clr,
  input  logic started,
  input  logic terminal,
  input  tok_t tok,
  input  logic buf_has_data,
  input  logic flush_en,
  output logic buf_clear,
  output logic tx_en
);
  logic ok_q, ok_d, err_q, err_d;
  logic clr_q, clr_d, tx_q, tx_d;
  logic frame_end;

  always_comb begin
    frame_end = cnt_clr || frame_tick;
    ok_d  = frame_end ? 1'b0 : (ok_q  || (started && tok.good));
    err_d = frame_end ? 1'b0 : (err_q || (started && tok.bad));
    clr_d = frame_tick && started && flush_en && buf_has_data && !cnt_clr &&
            (err_q || (terminal && !ok_q));
    tx_d  = tok.good && (!flush_en || terminal);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ok_q  <= 1'b0;
      err_q <= 1'b0;
      clr_q <= 1'b0;
      tx_q  <= 1'b0;
    end else begin
      ok_q  <= ok_d;
      err_q <= err_d;
      clr_q <= clr_d;
      tx_q  <= tx_d;
    end
  end

  assign buf_clear = clr_q;
  assign tx_en     = tx_q;

  AST_CLR_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    buf_clear |-> $past(buf_has_data)); // R5
  AST_CLR_ON_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    buf_clear |-> $past(frame_tick)); // R8
  AST_NO_CLR_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    buf_clear |-> $past(flush_en)); // R1
  AST_NO_TX_ON_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    tx_en |-> !$past(tok.bad)); // R4
endmodule

// File: rtl/iso_in_flush_ctrl.sv
module iso_in_flush_ctrl
  import iso_flush_pkg::*;
#(
  parameter int unsigned FRAME_CYCLES = 48000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sof_ok,
  input  logic       in_tok,
  input  logic       in_tok_err,
  input  logic       buf_has_data,
  input  logic       flush_en,
  input  logic [2:0] interval_sel,
  input  logic       auto_clr,
  input  logic       bus_reset,
  output logic       buf_clear,
  output logic       tx_en
);
  logic rst_meta_q, rst_sync_q;
  logic frame_tick, cnt_clr, started, terminal;
  tok_t tok;

  // Asynchronous assertion, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  always_comb begin
    tok.good = in_tok && !in_tok_err;
    tok.bad  = in_tok &&  in_tok_err;
    cnt_clr  = auto_clr || bus_reset;
  end

  sof_fill_timer #(.FRAME_CYCLES(FRAME_CYCLES)) u_timer (
    .clk        (clk),
    .rst_n      (rst_sync_q),
    .sof_ok     (sof_ok),
    .frame_tick (frame_tick)
  );

  interval_counter u_count (
    .clk        (clk),
    .rst_n      (rst_sync_q),
    .frame_tick (frame_tick),
    .cnt_clr    (cnt_clr),
    .sel        (isel_t'(interval_sel)),
    .started    (started),
    .terminal   (terminal)
  );

  flush_decider u_decide (
    .clk          (clk),
    .rst_n        (rst_sync_q),
    .frame_tick   (frame_tick),
    .cnt_clr      (cnt_clr),
    .started      (started),
    .terminal     (terminal),
    .tok          (tok),
    .buf_has_data (buf_has_data),
    .flush_en     (flush_en),
    .buf_clear    (buf_clear),
    .tx_en        (tx_en)
  );

  AST_NO_CLR_ON_SRC: assert property (@(posedge clk) disable iff (!rst_sync_q)
    cnt_clr |=> !buf_clear); // R7
  AST_CLR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (buf_clear && !$past(frame_tick, 1) ) |-> 1'b0 || !buf_clear); // R8
endmodule

// File: tb/test_iso_in_flush_ctrl.sv
module test_iso_in_flush_ctrl;
  localparam int FC = 40;

  logic       clk = 1'b0;
  logic       rst_n, sof_ok, in_tok, in_tok_err, buf_has_data, flush_en;
  logic [2:0] interval_sel;
  logic       auto_clr, bus_reset;
  logic       buf_clear, tx_en;

  int checks = 0, fails = 0;
  bit done = 0;

  // bench frame model
  int m_cnt, m_phase;
  bit m_started, m_ok, m_err;

  always #4 clk = ~clk;

  iso_in_flush_ctrl #(.FRAME_CYCLES(FC)) i_iso_in_flush_ctrl (
    .clk(clk), .rst_n(rst_n), .sof_ok(sof_ok), .in_tok(in_tok),
    .in_tok_err(in_tok_err), .buf_has_data(buf_has_data), .flush_en(flush_en),
    .interval_sel(interval_sel), .auto_clr(auto_clr), .bus_reset(bus_reset),
    .buf_clear(buf_clear), .tx_en(tx_en)
  );

  task automatic chk(input string tag, input string what, input bit act, input bit exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0b expected=%0b at %0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic bit exp_clear(bit tick, bit data, bit clr);
    int last = (1 << interval_sel) - 1;
    bit term = m_started && (m_phase >= last);
    return tick && m_started && flush_en && data && !clr && (m_err || (term && !m_ok));
  endfunction

  function automatic bit exp_tx(bit tok, bit err);
    int last = (1 << interval_sel) - 1;
    bit term = m_started && (m_phase >= last);
    return tok && !err && (!flush_en || term);
  endfunction

  task automatic step(input bit sof, input bit tok, input bit err, input bit data,
                      input bit aclr, input bit brst, input string tag);
    bit tick, clr, e_clr, e_tx;
    int last;
    @(negedge clk);
    sof_ok = sof; in_tok = tok; in_tok_err = err; buf_has_data = data;
    auto_clr = aclr; bus_reset = brst;
    tick  = sof || (m_cnt == FC - 1);
    clr   = aclr || brst;
    last  = (1 << interval_sel) - 1;
    e_clr = exp_clear(tick, data, clr);
    e_tx  = exp_tx(tok, err);
    m_cnt = tick ? 0 : m_cnt + 1;
    if (clr) begin
      m_started = 0; m_phase = 0; m_ok = 0; m_err = 0;
    end else begin
      if (tick) begin
        if (!m_started) begin m_started = 1; m_phase = 0; end
        else m_phase = (m_phase >= last) ? 0 : m_phase + 1;
        m_ok = 0; m_err = 0;
      end else begin
        m_ok  = m_ok  || (m_started && tok && !err);
        m_err = m_err || (m_started && tok && err);
      end
    end
    @(posedge clk); #1;
    chk(tag, "buf_clear", buf_clear, e_clr);
    chk(tag, "tx_en", tx_en, e_tx);
  endtask

  // One frame of FC cycles; SOF at cycle 0 unless dropped.
  task automatic frame(input bit drop, input int tokpos, input bit err, input bit data,
                       input int aclr_at, input int brst_at, input string tag);
    for (int c = 0; c < FC; c++)
      step(c == 0 && !drop, c == tokpos, c == tokpos && err, data,
           c == aclr_at, c == brst_at, tag);
  endtask

  task automatic do_reset;
    @(negedge clk);
    rst_n = 0; sof_ok = 0; in_tok = 0; in_tok_err = 0; buf_has_data = 0;
    auto_clr = 0; bus_reset = 0;
    m_cnt = 0; m_phase = 0; m_started = 0; m_ok = 0; m_err = 0;
    repeat (3) @(posedge clk);
    #1;
    chk("R7", "buf_clear in reset", buf_clear, 1'b0);
    chk("R7", "tx_en in reset", tx_en, 1'b0);
    @(negedge clk); rst_n = 1;
    repeat (3) @(posedge clk);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    flush_en = 0; interval_sel = 3'd1;
    do_reset();

    // R1: flushing off, every clean token answered, errors never
    for (int i = 0; i < 4; i++) frame(0, 10 + i, 0, 1, -1, -1, "R1");
    frame(0, 10, 1, 1, -1, -1, "R1");
    frame(0, -1, 0, 1, -1, -1, "R1");

    // R9 / R3: interval of one frame
    flush_en = 1; interval_sel = 3'd0;
    frame(0, 15, 0, 1, 3, -1, "R7");
    for (int i = 0; i < 3; i++) frame(0, 12, 0, 1, -1, -1, "R9");
    frame(0, -1, 0, 1, -1, -1, "R3");
    frame(0, 12, 0, 1, -1, -1, "R3");
    frame(0, -1, 0, 0, -1, -1, "R5");
    frame(0, 12, 0, 0, -1, -1, "R5");

    // R4: damaged token, then R8 coincident causes
    frame(0, 11, 1, 1, -1, -1, "R4");
    frame(0, 11, 0, 1, -1, -1, "R4");
    frame(0, 9, 1, 1, -1, -1, "R8");
    frame(0, 9, 0, 1, -1, -1, "R8");

    // R2: four-frame interval after auto-clear
    interval_sel = 3'd2;
    frame(0, -1, 0, 1, 5, -1, "R7");
    for (int k = 0; k < 2; k++)
      for (int p = 0; p < 4; p++) frame(0, (p == 3) ? 20 : -1, 0, 1, -1, -1, "R2");
    frame(0, 20, 0, 1, -1, -1, "R9");
    for (int p = 1; p < 4; p++) frame(0, -1, 0, 1, -1, -1, "R3");
    frame(0, 8, 1, 1, -1, -1, "R4");

    // R6: dropped SOFs, fill-in ticks carry the boundary
    interval_sel = 3'd0;
    frame(0, 14, 0, 1, -1, -1, "R6");
    frame(1, -1, 0, 1, -1, -1, "R6");
    frame(1, 14, 0, 1, -1, -1, "R6");
    frame(0, -1, 0, 1, -1, -1, "R6");
    frame(1, 14, 1, 1, -1, -1, "R6");
    frame(1, 14, 0, 1, -1, -1, "R6");

    // R7: bus reset mid-interval, then power-on reset
    interval_sel = 3'd1;
    frame(0, 16, 0, 1, -1, 25, "R7");
    frame(0, 16, 0, 1, -1, -1, "R7");
    frame(0, -1, 0, 1, -1, -1, "R7");
    do_reset();
    frame(0, 10, 0, 1, -1, -1, "R7");
    frame(0, -1, 0, 1, -1, -1, "R7");

    // Random mix
    for (int i = 0; i < 80; i++) begin
      if ($urandom_range(0, 9) == 0) begin
        flush_en = 1'($urandom_range(0, 1));
        interval_sel = 3'($urandom_range(0, 3));
      end
      frame($urandom_range(0, 99) < 15,
            ($urandom_range(0, 1) == 1) ? int'($urandom_range(3, 35)) : -1,
            $urandom_range(0, 99) < 15,
            $urandom_range(0, 99) < 80,
            ($urandom_range(0, 29) == 0) ? 7 : -1,
            ($urandom_range(0, 29) == 0) ? 30 : -1,
            flush_en ? "R3" : "R1");
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule